// File: doc/BRIEF.md
# Command Ring Consumer for an Interrupt Translation Unit

This block drains a ring of command records that software builds in system memory. Software first programs a queue descriptor register. That register holds the ring's base address, its size as a count of 4 KiB pages minus one, and a valid bit. Software then sets the global enable, writes records into the ring, and moves a byte-offset write pointer past them.

The engine compares its read pointer with the write pointer. Whenever they differ, the unit is enabled and the descriptor is valid, it fetches the 32-byte record at the read pointer. The fetch uses four 64-bit reads at ascending addresses. The engine then presents the assembled record to a downstream decoder over a valid/ready handshake. It moves the read pointer on by one record, wrapping at the end of the ring, only when the decoder accepts. Software polls the read pointer until it equals the write pointer it last wrote, which tells it all commands have been consumed.

A write pointer that is misaligned or outside the ring is rejected. The engine flags the error and stops fetching until software writes a good value.

Top module: `cmdq_engine`

## Requirements
- R1: After reset every register reads zero, `err_o`, `mem_req_o` and `cmd_valid_o` are low.
- R2: The ring holds (size field + 1) × 4096 bytes, size field = bits [7:0] of the descriptor; the read pointer steps by 32 and returns to 0 when it reaches the ring size.
- R3: No read is issued while the descriptor valid bit (bit 63) or the enable bit (control bit 0) is clear, or while the read pointer equals the write pointer.
- R4: Each record is fetched as four single-outstanding 64-bit reads at base + read pointer + 0, 8, 16, 24 in that order; the word from offset 8k appears at `cmd_data_o[64k+63:64k]`.
- R5: The read pointer advances only on a cycle where `cmd_valid_o` and `cmd_ready_i` are both high; while `cmd_valid_o` is high and `cmd_ready_i` low, `cmd_valid_o` and `cmd_data_o` hold.
- R6: The read pointer never moves past the write pointer: exactly one record is delivered per 32 bytes the write pointer advances, and fetching stops when they meet.
- R7: A write-pointer write whose bits [4:0] are nonzero or whose value is not below the ring size is discarded and sets `err_o`; while `err_o` is high no new record is fetched; a later valid write-pointer write clears `err_o`.
- R8: A write to the descriptor clears the read pointer, the write pointer and `err_o`.
- R9: Register map by `reg_addr_i`: 0 control (bit 0 enable), 1 descriptor (bits [7:0] size, bits [ADDR_W-1:12] base address, bit 63 valid, other bits read zero), 2 write pointer, 3 read pointer (writes ignored); `reg_rdata_o` shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data |
| mem_req_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | ADDR_W | Byte address of the read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| cmd_valid_o | output | 1 | Assembled record available |
| cmd_ready_i | input | 1 | Decoder accepts the record |
| cmd_data_o | output | 256 | Assembled record, word 0 in the low bits |
| err_o | output | 1 | Bad write pointer seen; fetching halted |

## Verification
The bench sweeps three ring sizes across more than one full lap. Chunk sizes vary and the decoder stalls at times. Each read address and record word is compared with a ring model. A design that wrapped at the wrong size, or not at all, would show the wrong address on the second lap. A design that moved the pointer on fetch rather than on accept would show the wrong pointer or changed data during stalls. Separate scenarios hold the engine disabled, leave the descriptor invalid, and write misaligned and out-of-range pointers. A design that leaks a fetch or keeps a bad pointer would show extra reads or a moved read pointer.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int WORD_W     = 64;
  localparam int BEATS      = 4;
  localparam int REC_BYTES  = WORD_W / 8 * BEATS;
  localparam int PAGE_SH    = 12;
  localparam int SZ_FIELD_W = 8;
  localparam int VALID_BIT  = 63;

  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_QBASE = 2'd1;
  localparam logic [1:0] REG_WPTR  = 2'd2;
  localparam logic [1:0] REG_RPTR  = 2'd3;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_WAIT, F_OUT} fetch_st_e;
endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = SZ_FIELD_W + PAGE_SH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  input  logic              adv_i,
  output logic              en_o,
  output logic              qvalid_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [PTR_W-1:0]  rd_o,
  output logic [PTR_W-1:0]  wr_o,
  output logic              err_o
);
  localparam int SZ_W = PTR_W + 1;

  logic                     en_q, valid_q, err_q;
  logic [SZ_FIELD_W-1:0]    size_q;
  logic [ADDR_W-PAGE_SH-1:0] base_q;
  logic [PTR_W-1:0]         rd_q, wr_q;
  logic [SZ_W-1:0]          qsize, rd_inc;
  logic [PTR_W-1:0]         rd_wrap;
  logic                     wr_bad;

  assign qsize   = (SZ_W'(size_q) + SZ_W'(1)) << PAGE_SH;
  assign rd_inc  = SZ_W'(rd_q) + SZ_W'(REC_BYTES);
  assign rd_wrap = (rd_inc == qsize) ? '0 : rd_inc[PTR_W-1:0];
  assign wr_bad  = (|wdata_i[4:0]) || (wdata_i >= 64'(qsize));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      size_q  <= '0;
      base_q  <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
    end else begin
      if (adv_i) rd_q <= rd_wrap;
      if (we_i) begin
        unique case (addr_i)
          REG_CTRL: en_q <= wdata_i[0];
          REG_QBASE: begin
            size_q  <= wdata_i[SZ_FIELD_W-1:0];
            base_q  <= wdata_i[ADDR_W-1:PAGE_SH];
            valid_q <= wdata_i[VALID_BIT];
            rd_q    <= '0;
            wr_q    <= '0;
            err_q   <= 1'b0;
          end
          REG_WPTR: begin
            if (wr_bad) err_q <= 1'b1;
            else begin
              wr_q  <= wdata_i[PTR_W-1:0];
              err_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL:  rdata_o[0] = en_q;
      REG_QBASE: begin
        rdata_o[SZ_FIELD_W-1:0]     = size_q;
        rdata_o[ADDR_W-1:PAGE_SH]   = base_q;
        rdata_o[VALID_BIT]          = valid_q;
      end
      REG_WPTR:  rdata_o = 64'(wr_q);
      default:   rdata_o = 64'(rd_q);
    endcase
  end

  assign en_o     = en_q;
  assign qvalid_o = valid_q;
  assign base_o   = {base_q, {PAGE_SH{1'b0}}};
  assign rd_o     = rd_q;
  assign wr_o     = wr_q;
  assign err_o    = err_q;

  AST_NO_PASS_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> rd_q != wr_q); // R6
  AST_RD_IN_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q[4:0] == 5'd0) && (SZ_W'(rd_q) < qsize)); // R2
  AST_BAD_WR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_WPTR && wr_bad) |=> (wr_q == $past(wr_q)) && err_q); // R7
endmodule

// File: rtl/cmdq_fetch.sv
module cmdq_fetch
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = SZ_FIELD_W + PAGE_SH
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    qvalid_i,
  input  logic                    err_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic [PTR_W-1:0]        rd_i,
  input  logic [PTR_W-1:0]        wr_i,
  output logic                    mem_req_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic                    mem_rvalid_i,
  input  logic [WORD_W-1:0]       mem_rdata_i,
  output logic                    cmd_valid_o,
  input  logic                    cmd_ready_i,
  output logic [BEATS*WORD_W-1:0] cmd_data_o,
  output logic                    adv_o
);
  localparam int BEAT_W = $clog2(BEATS);

  fetch_st_e         st_q;
  logic [BEAT_W-1:0] beat_q;
  logic [WORD_W-1:0] words_q [BEATS];
  logic              go;

  assign go = en_i && qvalid_i && !err_i && (rd_i != wr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= F_IDLE;
      beat_q <= '0;
      for (int i = 0; i < BEATS; i++) words_q[i] <= '0;
    end else begin
      unique case (st_q)
        F_IDLE: if (go) begin
          st_q   <= F_REQ;
          beat_q <= '0;
        end
        F_REQ: st_q <= F_WAIT;
        F_WAIT: if (mem_rvalid_i) begin
          words_q[beat_q] <= mem_rdata_i;
          if (beat_q == BEAT_W'(BEATS - 1)) st_q <= F_OUT;
          else begin
            beat_q <= beat_q + BEAT_W'(1);
            st_q   <= F_REQ;
          end
        end
        F_OUT: if (cmd_ready_i) st_q <= F_IDLE;
        default: st_q <= F_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (st_q == F_REQ);
  assign mem_addr_o  = base_i + ADDR_W'(rd_i) + ADDR_W'({beat_q, 3'b000});
  assign cmd_valid_o = (st_q == F_OUT);
  assign adv_o       = cmd_valid_o && cmd_ready_i;

  for (genvar g = 0; g < BEATS; g++) begin : g_pack
    assign cmd_data_o[g*WORD_W +: WORD_W] = words_q[g];
  end

  AST_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && beat_q == '0) |-> $past(en_i && qvalid_i && !err_i && rd_i != wr_i)); // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R4
  AST_HOLD_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i) |=> cmd_valid_o && $stable(cmd_data_o)); // R5
  AST_ERR_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == F_IDLE && err_i) |=> !mem_req_o); // R7
endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [1:0]              reg_addr_i,
  input  logic [63:0]             reg_wdata_i,
  output logic [63:0]             reg_rdata_o,
  output logic                    mem_req_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic                    mem_rvalid_i,
  input  logic [WORD_W-1:0]       mem_rdata_i,
  output logic                    cmd_valid_o,
  input  logic                    cmd_ready_i,
  output logic [BEATS*WORD_W-1:0] cmd_data_o,
  output logic                    err_o
);
  localparam int PTR_W = SZ_FIELD_W + PAGE_SH;

  logic              en, qvalid, err, adv;
  logic [ADDR_W-1:0] base;
  logic [PTR_W-1:0]  rd, wr;

  cmdq_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .adv_i    (adv),
    .en_o     (en),
    .qvalid_o (qvalid),
    .base_o   (base),
    .rd_o     (rd),
    .wr_o     (wr),
    .err_o    (err)
  );

  cmdq_fetch #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en),
    .qvalid_i     (qvalid),
    .err_i        (err),
    .base_i       (base),
    .rd_i         (rd),
    .wr_i         (wr),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_ready_i  (cmd_ready_i),
    .cmd_data_o   (cmd_data_o),
    .adv_o        (adv)
  );

  assign err_o = err;
endmodule

// File: tb/tb_cmdq_engine.sv
`timescale 1ns/1ps
module tb_cmdq_engine;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              reg_we = 1'b0;
  logic [1:0]        reg_addr = 2'd0;
  logic [63:0]       reg_wdata = '0;
  logic [63:0]       reg_rdata;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rvalid = 1'b0;
  logic [63:0]       mem_rdata = '0;
  logic              cmd_valid;
  logic              cmd_ready = 1'b1;
  logic [255:0]      cmd_data;
  logic              err;

  cmdq_engine #(.ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_data_o(cmd_data), .err_o(err)
  );

  int n_chk = 0, n_bad = 0;
  int req_cnt = 0, acc_cnt = 0, beat = 0, exp_rd = 0, q_size = 4096;
  logic [31:0] q_addr = '0;
  logic [7:0]  lfsr = 8'h5B;
  bit          stall_mode = 1'b0;
  bit          hold_pend = 1'b0;
  logic [255:0] held;

  function automatic logic [63:0] mw(input logic [31:0] a);
    return {a ^ 32'hA5A5_0000, ~a};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h @%0t", req, act, exp, $time);
    end
  endtask

  // memory model: one-cycle latency
  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mw(mem_addr);
  end

  // decoder model and monitors
  always @(negedge clk) if (rst_n) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cmd_ready = stall_mode ? (lfsr[0] & lfsr[2]) : 1'b1;
    if (hold_pend) begin
      chk(cmd_valid == 1'b1, "R5 valid held", cmd_valid, 1);
      chk(cmd_data == held, "R5 data held", cmd_data[63:0], held[63:0]);
    end
    if (mem_req) begin
      req_cnt++;
      chk(mem_addr == q_addr + 32'(exp_rd) + 32'(8 * beat), "R4 read address",
          mem_addr, q_addr + 32'(exp_rd) + 32'(8 * beat));
      beat = (beat + 1) % 4;
    end
    if (cmd_valid && cmd_ready) begin
      for (int k = 0; k < 4; k++) begin
        logic [63:0] ew;
        ew = mw(q_addr + 32'(exp_rd) + 32'(8 * k));
        chk(cmd_data[64*k +: 64] == ew, "R4 record word", cmd_data[64*k +: 64], ew);
      end
      exp_rd = (exp_rd + 32) % q_size;
      acc_cnt++;
    end
    hold_pend = cmd_valid && !cmd_ready;
    held      = cmd_data;
  end

  task automatic reg_wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic drain(input int target);
    logic [63:0] v;
    int r0;
    for (int i = 0; i < 20000; i++) begin
      reg_rd(2'd3, v);
      if (v == 64'(target)) break;
    end
    r0 = req_cnt;
    repeat (20) @(negedge clk);
    chk(req_cnt == r0, "R6 idle when pointers meet", req_cnt, r0);
  endtask

  task automatic set_queue(input logic [31:0] base, input int field, input bit vld);
    q_addr = base; q_size = (field + 1) * 4096; exp_rd = 0; beat = 0;
    reg_wr(2'd1, (64'(vld) << 63) | 64'(base) | 64'(field));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] v;
    int r0, a0, wr, total, chunk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      reg_rd(2'(a), v);
      chk(v == 0, "R1 register reset", v, 0);
    end
    chk(err == 0 && cmd_valid == 0 && mem_req == 0, "R1 outputs reset", {err, cmd_valid, mem_req}, 0);

    // R3: enabled but descriptor invalid
    reg_wr(2'd0, 64'd1);
    set_queue(32'h0000_2000, 0, 1'b0);
    r0 = req_cnt;
    reg_wr(2'd2, 64'd64);
    repeat (40) @(negedge clk);
    reg_rd(2'd3, v);
    chk(v == 0, "R3 no progress while invalid", v, 0);
    chk(req_cnt == r0, "R3 no reads while invalid", req_cnt, r0);

    // R8 descriptor write clears pointers; R3 disabled
    reg_wr(2'd0, 64'd0);
    set_queue(32'h0000_2000, 0, 1'b1);
    reg_rd(2'd2, v);
    chk(v == 0, "R8 write pointer cleared", v, 0);
    reg_wr(2'd2, 64'd64);
    repeat (40) @(negedge clk);
    reg_rd(2'd3, v);
    chk(v == 0, "R3 no progress while disabled", v, 0);
    chk(req_cnt == r0, "R3 no reads while disabled", req_cnt, r0);
    a0 = acc_cnt;
    reg_wr(2'd0, 64'd1);
    drain(64);
    chk(acc_cnt - a0 == 2, "R6 two records delivered", acc_cnt - a0, 2);

    // R9 register readback
    reg_rd(2'd0, v);
    chk(v == 1, "R9 control readback", v, 1);
    reg_rd(2'd1, v);
    chk(v == 64'h8000_0000_0000_2000, "R9 descriptor readback", v, 64'h8000_0000_0000_2000);
    reg_wr(2'd3, 64'd512);
    reg_rd(2'd3, v);
    chk(v == 64, "R9 read pointer write ignored", v, 64);
    set_queue(32'h0000_2000, 0, 1'b1);
    reg_wr(2'd1, 64'h8000_0100_0000_2000);
    reg_rd(2'd1, v);
    chk(v == 64'h8000_0000_0000_2000, "R9 unused bits read zero", v, 64'h8000_0000_0000_2000);

    // R7 bad write pointers
    reg_wr(2'd2, 64'd64);
    drain(64);
    reg_wr(2'd2, 64'd65);
    chk(err == 1, "R7 misaligned flags error", err, 1);
    reg_rd(2'd2, v);
    chk(v == 64, "R7 misaligned discarded", v, 64);
    reg_wr(2'd2, 64'd4096);
    reg_rd(2'd2, v);
    chk(err == 1 && v == 64, "R7 out of range discarded", v, 64);
    reg_wr(2'd2, 64'd128);
    chk(err == 0, "R7 good write clears error", err, 0);
    drain(128);
    reg_wr(2'd0, 64'd0);
    reg_wr(2'd2, 64'd160);
    reg_wr(2'd2, 64'd161);
    r0 = req_cnt;
    reg_wr(2'd0, 64'd1);
    repeat (40) @(negedge clk);
    reg_rd(2'd3, v);
    chk(v == 128, "R7 error halts fetch", v, 128);
    chk(req_cnt == r0, "R7 no reads under error", req_cnt, r0);
    reg_wr(2'd2, 64'd160);
    drain(160);
    reg_rd(2'd3, v);
    chk(v == 160, "R7 resumes after good write", v, 160);
    reg_wr(2'd1, 64'h8000_0000_0000_2000);
    q_size = 4096; exp_rd = 0; beat = 0;
    reg_wr(2'd2, 64'd3);
    reg_wr(2'd1, 64'h8000_0000_0000_2000);
    chk(err == 0, "R8 descriptor write clears error", err, 0);

    // R2/R4/R5/R6 sweep over ring sizes and laps
    for (int f = 0; f < 3; f++) begin
      stall_mode = (f != 0);
      set_queue(32'h0010_0000 * 32'(f + 1), f, 1'b1);
      wr = 0; total = 0; chunk = 1;
      while (total < (q_size / 32) * 3 / 2) begin
        wr = (wr + 32 * chunk) % q_size;
        a0 = acc_cnt; r0 = req_cnt;
        reg_wr(2'd2, 64'(wr));
        drain(wr);
        reg_rd(2'd3, v);
        chk(v == 64'(wr), "R2 read pointer after wrap", v, wr);
        chk(acc_cnt - a0 == chunk, "R6 records per chunk", acc_cnt - a0, chunk);
        chk(req_cnt - r0 == 4 * chunk, "R4 four reads per record", req_cnt - r0, 4 * chunk);
        total += chunk;
        chunk = chunk % 37 + 5;
      end
    end
    stall_mode = 1'b0;

    summary();
    $finish;
  end
endmodule